// File: doc/BRIEF.md
# Dual-Clock Qualified-Access FIFO

This block moves 36-bit words from one clock domain to another through 64 entries of storage. The write side and the read side each have their own free-running clock. On either side a transfer takes place only when four control inputs (a select, a direction, a side-channel select and an enable) are all at the levels that side expects. Any other combination leaves the queue untouched.

The write side drives an active-low full indication. The read side drives an active-low almost-empty indication, which stays asserted while the number of stored words is no more than a fixed threshold. Each flag uses its own side's pointer and a copy of the other side's pointer that has passed through a two-stage synchronizer. A change made by the far side therefore reaches the flag two or three local clock edges later. Read data comes from an output register that changes only when an accepted read takes place.

Top module: `xclk_gated_fifo`

## Requirements
- R1: Words leave the queue in the order they were accepted, with their 36-bit values unchanged, and up to 64 words can be held at once.
- R2: A write is accepted on a rising `wrClk` edge only when `wrSelN`=0, `wrDir`=1, `wrMbx`=0 and `wrEn`=1. Any other combination stores nothing.
- R3: A read is accepted on a rising `rdClk` edge only when `rdSelN`=0, `rdDir`=0, `rdMbx`=0, `rdEn`=1 and the read side sees at least one word. An accepted read loads the oldest word into `rdData` at that edge.
- R4: `rdData` keeps its value on every edge without an accepted read, including a read attempted while the queue is empty.
- R5: A write attempted while `fullN` is low is ignored: the word is never read out.
- R6: `fullN` is low whenever 64 words are held. After a read frees an entry, it returns high on the second or third rising `wrClk` edge following that read.
- R7: `almostEmptyN` is low while the stored count is at most `AE_LEVEL` (default 8). When a write raises the count from `AE_LEVEL` to `AE_LEVEL`+1, it goes high on the second or third rising `rdClk` edge after that write.
- R8: `almostEmptyN` goes low on the same `rdClk` edge as the read that brings the count down to `AE_LEVEL`.
- R9: While `rstN` is low, and after it is released, the queue is empty, `fullN` is 1, `almostEmptyN` is 0 and `rdData` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock |
| rdClk | input | 1 | Read-side clock |
| rstN | input | 1 | Asynchronous active-low reset for both sides |
| wrSelN | input | 1 | Write-side select, active low |
| wrDir | input | 1 | Write-side direction; 1 selects a write |
| wrMbx | input | 1 | Write-side side-channel select; must be 0 |
| wrEn | input | 1 | Write-side enable, active high |
| wrData | input | 36 | Word to store |
| fullN | output | 1 | Active-low full flag, write domain |
| rdSelN | input | 1 | Read-side select, active low |
| rdDir | input | 1 | Read-side direction; 0 selects a read |
| rdMbx | input | 1 | Read-side side-channel select; must be 0 |
| rdEn | input | 1 | Read-side enable, active high |
| rdData | output | 36 | Registered read word |
| almostEmptyN | output | 1 | Active-low almost-empty flag, read domain |

## Verification
A write or read pointer that moves when it should not shows up at the next accepted read as a word out of order, a repeated word or a missing word. A stuck or wrong synchronized pointer shows up as a flag that misses its two-to-three-edge window. The bench therefore times every flag transition in local clock edges from the far-side transfer that caused it. It also drains the queue after each phase, so that any stored word that should have been dropped comes out as a visible mismatch.

// File: rtl/xclk_fifo_pkg.sv
package xclk_fifo_pkg;
  // Strobes from control to datapath; each bit lives in its own clock domain.
  typedef struct packed {
    logic wrCommit;  // write domain: store wrData at wrAddr
    logic rdCommit;  // read domain: load the output register from rdAddr
  } fifoStrobe_t;
endpackage

// File: rtl/xclk_sync2.sv
module xclk_sync2 #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      dout   <= '0;
    end else begin
      stage1 <= din;
      dout   <= stage1;
    end
  end
endmodule

// File: rtl/xclk_fifo_ctrl.sv
module xclk_fifo_ctrl
  import xclk_fifo_pkg::*;
#(
  parameter  int DEPTH    = 64,
  parameter  int AE_LEVEL = 8,
  localparam int AW       = $clog2(DEPTH),
  localparam int PW       = AW + 1
) (
  input  logic          wrClk,
  input  logic          rdClk,
  input  logic          rstN,
  input  logic          wrReq,
  input  logic          rdReq,
  output fifoStrobe_t   strobe,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output logic          fullN,
  output logic          almostEmptyN,
  output logic [PW-1:0] wrFill,
  output logic [PW-1:0] rdFill,
  output logic [PW-1:0] wrPtrBin,
  output logic [PW-1:0] rdPtrBin
);
  function automatic logic [PW-1:0] toGray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] fromGray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PW-1:0] wrBin, rdBin, wrGray, rdGray;
  logic [PW-1:0] rdGraySyncW, wrGraySyncR;
  logic [PW-1:0] wrBinNext, rdBinNext;

  assign wrBinNext = wrBin + 1'b1;
  assign rdBinNext = rdBin + 1'b1;

  // Write-domain pointer, binary plus Gray copy for crossing
  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrBin  <= '0;
      wrGray <= '0;
    end else if (strobe.wrCommit) begin
      wrBin  <= wrBinNext;
      wrGray <= toGray(wrBinNext);
    end
  end

  // Read-domain pointer
  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdBin  <= '0;
      rdGray <= '0;
    end else if (strobe.rdCommit) begin
      rdBin  <= rdBinNext;
      rdGray <= toGray(rdBinNext);
    end
  end

  xclk_sync2 #(.W(PW)) rdToWrSync (
    .clk (wrClk), .rstN(rstN), .din(rdGray), .dout(rdGraySyncW)
  );
  xclk_sync2 #(.W(PW)) wrToRdSync (
    .clk (rdClk), .rstN(rstN), .din(wrGray), .dout(wrGraySyncR)
  );

  // Occupancy as each side sees it
  assign wrFill = wrBin - fromGray(rdGraySyncW);
  assign rdFill = fromGray(wrGraySyncR) - rdBin;

  assign fullN        = (wrFill != PW'(DEPTH));
  assign almostEmptyN = (rdFill > PW'(AE_LEVEL));

  assign strobe.wrCommit = wrReq & fullN;
  assign strobe.rdCommit = rdReq & (rdFill != '0);

  assign wrAddr   = wrBin[AW-1:0];
  assign rdAddr   = rdBin[AW-1:0];
  assign wrPtrBin = wrBin;
  assign rdPtrBin = rdBin;
endmodule

// File: rtl/xclk_fifo_data.sv
module xclk_fifo_data
  import xclk_fifo_pkg::*;
#(
  parameter  int WIDTH = 36,
  parameter  int DEPTH = 64,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic             wrClk,
  input  logic             rdClk,
  input  logic             rstN,
  input  fifoStrobe_t      strobe,
  input  logic [AW-1:0]    wrAddr,
  input  logic [AW-1:0]    rdAddr,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData
);
  logic [WIDTH-1:0] store [DEPTH];

  always_ff @(posedge wrClk) begin
    if (strobe.wrCommit) store[wrAddr] <= wrData;
  end

  // Output register: holds until an accepted read
  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)                rdData <= '0;
    else if (strobe.rdCommit) rdData <= store[rdAddr];
  end
endmodule

// File: rtl/xclk_gated_fifo.sv
module xclk_gated_fifo
  import xclk_fifo_pkg::*;
#(
  parameter  int WIDTH    = 36,
  parameter  int DEPTH    = 64,
  parameter  int AE_LEVEL = 8,
  localparam int AW       = $clog2(DEPTH),
  localparam int PW       = AW + 1
) (
  input  logic             wrClk,
  input  logic             rdClk,
  input  logic             rstN,
  input  logic             wrSelN,
  input  logic             wrDir,
  input  logic             wrMbx,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  output logic             fullN,
  input  logic             rdSelN,
  input  logic             rdDir,
  input  logic             rdMbx,
  input  logic             rdEn,
  output logic [WIDTH-1:0] rdData,
  output logic             almostEmptyN
);
  fifoStrobe_t   strobe;
  logic [AW-1:0] wrAddr, rdAddr;
  logic [PW-1:0] wrFill, rdFill, wrPtrBin, rdPtrBin;
  logic          wrReq, rdReq;

  // Port qualification
  assign wrReq = ~wrSelN &  wrDir & ~wrMbx & wrEn;
  assign rdReq = ~rdSelN & ~rdDir & ~rdMbx & rdEn;

  xclk_fifo_ctrl #(.DEPTH(DEPTH), .AE_LEVEL(AE_LEVEL)) ctrl_i (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .wrReq(wrReq), .rdReq(rdReq), .strobe(strobe),
    .wrAddr(wrAddr), .rdAddr(rdAddr),
    .fullN(fullN), .almostEmptyN(almostEmptyN),
    .wrFill(wrFill), .rdFill(rdFill),
    .wrPtrBin(wrPtrBin), .rdPtrBin(rdPtrBin)
  );

  xclk_fifo_data #(.WIDTH(WIDTH), .DEPTH(DEPTH)) data_i (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .strobe(strobe),
    .wrAddr(wrAddr), .rdAddr(rdAddr),
    .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: rtl/xclk_fifo_chk.sv
module xclk_fifo_chk #(
  parameter  int WIDTH    = 36,
  parameter  int DEPTH    = 64,
  localparam int PW       = $clog2(DEPTH) + 1
) (
  input logic             wrClk,
  input logic             rdClk,
  input logic             rstN,
  input logic             wrSelN,
  input logic             wrDir,
  input logic             wrMbx,
  input logic             wrEn,
  input logic             fullN,
  input logic             rdSelN,
  input logic             rdDir,
  input logic             rdMbx,
  input logic             rdEn,
  input logic [WIDTH-1:0] rdData,
  input logic             almostEmptyN,
  input logic [PW-1:0]    wrFill,
  input logic [PW-1:0]    rdFill,
  input logic [PW-1:0]    wrPtrBin,
  input logic [PW-1:0]    rdPtrBin
);
  logic wrQual, rdQual;
  assign wrQual = ~wrSelN &  wrDir & ~wrMbx & wrEn;
  assign rdQual = ~rdSelN & ~rdDir & ~rdMbx & rdEn;

  // R5
  no_overflow_chk: assert property (@(posedge wrClk) disable iff (!rstN)
    wrFill <= PW'(DEPTH));

  // R5
  full_blocks_write_chk: assert property (@(posedge wrClk) disable iff (!rstN)
    !fullN |=> $stable(wrPtrBin));

  // R2
  unqualified_write_chk: assert property (@(posedge wrClk) disable iff (!rstN)
    !wrQual |=> $stable(wrPtrBin));

  // R3
  read_step_chk: assert property (@(posedge rdClk) disable iff (!rstN)
    (rdQual && rdFill != '0) |=> rdPtrBin == $past(rdPtrBin) + 1'b1);

  // R4
  hold_output_chk: assert property (@(posedge rdClk) disable iff (!rstN)
    !rdQual |=> $stable(rdData));

  // R4
  empty_read_chk: assert property (@(posedge rdClk) disable iff (!rstN)
    (rdFill == '0) |=> $stable(rdData));

  // R7
  ae_when_empty_chk: assert property (@(posedge rdClk) disable iff (!rstN)
    (rdFill == '0) |-> !almostEmptyN);
endmodule

bind xclk_gated_fifo xclk_fifo_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) chk_i (
  .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
  .wrSelN(wrSelN), .wrDir(wrDir), .wrMbx(wrMbx), .wrEn(wrEn), .fullN(fullN),
  .rdSelN(rdSelN), .rdDir(rdDir), .rdMbx(rdMbx), .rdEn(rdEn),
  .rdData(rdData), .almostEmptyN(almostEmptyN),
  .wrFill(wrFill), .rdFill(rdFill), .wrPtrBin(wrPtrBin), .rdPtrBin(rdPtrBin)
);

// File: tb/xclk_gated_fifo_tb_top.sv
`timescale 1ns/100ps
module xclk_gated_fifo_tb_top;
  logic        wrClk, rdClk, rstN;
  logic        wrSelN, wrDir, wrMbx, wrEn;
  logic [35:0] wrData;
  logic        fullN;
  logic        rdSelN, rdDir, rdMbx, rdEn;
  logic [35:0] rdData;
  logic        almostEmptyN;

  int          checks = 0;
  int          fails  = 0;
  logic [35:0] model[$];
  logic [35:0] lastOut;

  xclk_gated_fifo dut_i (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .wrSelN(wrSelN), .wrDir(wrDir), .wrMbx(wrMbx), .wrEn(wrEn),
    .wrData(wrData), .fullN(fullN),
    .rdSelN(rdSelN), .rdDir(rdDir), .rdMbx(rdMbx), .rdEn(rdEn),
    .rdData(rdData), .almostEmptyN(almostEmptyN)
  );

  // 100 MHz write clock; unrelated read clock with an offset
  initial begin wrClk = 0; forever #5 wrClk = ~wrClk; end
  initial begin rdClk = 0; #3.3; forever #6.5 rdClk = ~rdClk; end

  // {isWrite, selN, dir, mbx, en, accepted}
  localparam logic [5:0] VEC [32] = '{
    6'b1_0000_0, 6'b1_0001_0, 6'b1_0010_0, 6'b1_0011_0,
    6'b1_0100_0, 6'b1_0101_1, 6'b1_0110_0, 6'b1_0111_0,
    6'b1_1000_0, 6'b1_1001_0, 6'b1_1010_0, 6'b1_1011_0,
    6'b1_1100_0, 6'b1_1101_0, 6'b1_1110_0, 6'b1_1111_0,
    6'b0_0000_0, 6'b0_0001_1, 6'b0_0010_0, 6'b0_0011_0,
    6'b0_0100_0, 6'b0_0101_0, 6'b0_0110_0, 6'b0_0111_0,
    6'b0_1000_0, 6'b0_1001_0, 6'b0_1010_0, 6'b0_1011_0,
    6'b0_1100_0, 6'b0_1101_0, 6'b0_1110_0, 6'b0_1111_0
  };

  task automatic check(input bit ok, input string req,
                       input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrOp(input logic s, d, m, e, input logic [35:0] dat);
    @(negedge wrClk);
    wrSelN = s; wrDir = d; wrMbx = m; wrEn = e; wrData = dat;
    @(posedge wrClk);
    wrEn <= 1'b0; wrSelN <= 1'b1;
  endtask

  task automatic rdOp(input logic s, d, m, e);
    @(negedge rdClk);
    rdSelN = s; rdDir = d; rdMbx = m; rdEn = e;
    @(posedge rdClk);
    rdEn <= 1'b0; rdSelN <= 1'b1;
  endtask

  task automatic pushWord(input logic [35:0] dat);
    wrOp(1'b0, 1'b1, 1'b0, 1'b1, dat);
    model.push_back(dat);
  endtask

  task automatic popCheck(input string req);
    logic [35:0] exp;
    rdOp(1'b0, 1'b0, 1'b0, 1'b1);
    #1;
    exp = model.pop_front();
    check(rdData === exp, req, rdData, exp);
    lastOut = rdData;
  endtask

  task automatic settle();
    repeat (6) @(posedge rdClk);
    repeat (6) @(posedge wrClk);
  endtask

  // Watchdog
  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int n;
    logic [35:0] exp;
    rstN = 0;
    wrSelN = 1; wrDir = 0; wrMbx = 0; wrEn = 0; wrData = '0;
    rdSelN = 1; rdDir = 1; rdMbx = 0; rdEn = 0;
    repeat (4) @(posedge wrClk);
    #2;
    // R9 values during reset
    check(fullN === 1'b1, "R9 fullN", {35'd0, fullN}, 36'd1);
    check(almostEmptyN === 1'b0, "R9 almostEmptyN", {35'd0, almostEmptyN}, 36'd0);
    rstN = 1;
    settle();
    check(rdData === '0, "R9 rdData", rdData, '0);
    lastOut = rdData;

    // Vector walk, write side (R2)
    for (int i = 0; i < 16; i++) begin
      wrOp(VEC[i][4], VEC[i][3], VEC[i][2], VEC[i][1], 36'hA00 + 36'(i));
      if (VEC[i][0]) model.push_back(36'hA00 + 36'(i));
    end
    for (int i = 0; i < 10; i++) pushWord(36'hB00 + 36'(i));
    settle();
    check(32'(model.size()) == 11, "R2 accepted writes", 36'(model.size()), 36'd11);

    // Vector walk, read side (R3, R4)
    for (int i = 16; i < 32; i++) begin
      rdOp(VEC[i][4], VEC[i][3], VEC[i][2], VEC[i][1]);
      #1;
      if (VEC[i][0]) begin
        exp = model.pop_front();
        check(rdData === exp, "R3 qualified read", rdData, exp);
      end else begin
        check(rdData === lastOut, "R4 unqualified read holds", rdData, lastOut);
      end
      lastOut = rdData;
    end

    // Drain in order (R1), then an empty read holds (R4)
    while (model.size() > 0) popCheck("R1 order");
    settle();
    rdOp(1'b0, 1'b0, 1'b0, 1'b1);
    #1;
    check(rdData === lastOut, "R4 empty read holds", rdData, lastOut);

    // Almost-empty threshold (R7, R8)
    for (int i = 0; i < 8; i++) pushWord(36'hC00 + 36'(i));
    settle();
    check(almostEmptyN === 1'b0, "R7 count 8 asserted", {35'd0, almostEmptyN}, 36'd0);
    pushWord(36'hC08);
    n = 0;
    do begin @(posedge rdClk); n++; #1; end while (!almostEmptyN && n < 8);
    check(n >= 2 && n <= 3, "R7 rise latency", 36'(n), 36'd2);
    popCheck("R1 order");
    check(almostEmptyN === 1'b0, "R8 falls at read edge", {35'd0, almostEmptyN}, 36'd0);
    while (model.size() > 0) popCheck("R1 order");
    settle();

    // Full flag (R5, R6)
    for (int i = 0; i < 64; i++) pushWord(36'hD000 + 36'(i));
    #1;
    check(fullN === 1'b0, "R6 full at 64", {35'd0, fullN}, 36'd0);
    wrOp(1'b0, 1'b1, 1'b0, 1'b1, 36'hDEAD);
    settle();
    check(fullN === 1'b0, "R5 still full", {35'd0, fullN}, 36'd0);
    rdOp(1'b0, 1'b0, 1'b0, 1'b1);
    n = 0;
    do begin @(posedge wrClk); n++; #1; end while (!fullN && n < 8);
    check(n >= 2 && n <= 3, "R6 rise latency", 36'(n), 36'd2);
    exp = model.pop_front();
    check(rdData === exp, "R1 first of full", rdData, exp);
    lastOut = rdData;
    while (model.size() > 0) popCheck("R5 dropped word absent");
    settle();
    rdOp(1'b0, 1'b0, 1'b0, 1'b1);
    #1;
    check(rdData === lastOut, "R5 no extra word", rdData, lastOut);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule